// File: doc/BRIEF.md
# Trap Entry and Vector Unit

This block performs entry into a trap for a 64-bit processor with register windows in one accepted request. The caller presents a 9-bit trap type together with the current program counter pair, condition codes, address-space identifier, processor state word, window pointer, count of savable windows, global level, trap level and trap base address. On acceptance the unit pushes a saved-state record onto an internal stack, selected by the new trap level. It registers the updated trap level, processor state, window pointer and global level, and it registers the handler program counter pair.

When the trap level is already at its ceiling, the unit does not enter the trap. It reports an error state and echoes the incoming state unchanged. A separate registered read port lets the surrounding logic inspect any stack level.

The processor state word is 12 bits wide with these fields: bit 0 alternate globals, bit 1 interrupt enable, bit 2 privileged, bit 3 address mask, bit 4 FPU enable, bit 5 RED, bits 7:6 memory model, bit 8 trap-level enable, bit 9 little-endian, bit 10 MMU globals, bit 11 interrupt globals.

Top module: `trap_entry_unit`

## Requirements
- R1: `req_ready` is low during reset and high afterwards. `done` rises in the cycle after each accepted request and stays high for one cycle only. During reset, `done`, `err_state` and all registered state outputs are zero.
- R2: If `cur_tl` is at or above MAXTL (default 6), `done` comes with `err_state` high. `new_tl`, `new_pstate`, `new_cwp` and `new_gl` then equal their inputs, `hdl_pc`/`hdl_npc` equal `cur_pc`/`cur_npc`, and no stack entry is written.
- R3: Otherwise `new_tl` is `cur_tl`+1. When `cur_tl` equals MAXTL-1, RED (bit 5) is set, both in the saved state word and in `new_pstate`.
- R4: The saved state word carries several fields. CCR is in bits 39:32, ASI in bits 31:24, and the RED-adjusted processor state ANDed with 0xF3F is in bits 19:8. The window pointer is in the low bits, and every other bit is zero.
- R5: The entry at index `new_tl` also stores the incoming PC, NPC and trap type. All four fields can be read back on `rd_*` one cycle after `rd_lvl` is set.
- R6: With the global-level feature on (default), `cur_gl` is stored in bits 42:40 of the saved word, and `new_gl` is `cur_gl`+1 modulo 8.
- R7: `new_pstate` has FPU enable (bit 4) and privileged (bit 2) set. Exactly one global-select bit is set, and every other bit is clear except RED under R3. The global-select bit depends on the trap type:
  - interrupt globals (bit 11) for type 0x060;
  - MMU globals (bit 10) for 0x008, 0x030 and 0x064 to 0x06F;
  - alternate globals (bit 0) for all other types, including the 0x100 to 0x1FF trap-instruction ranges.
- R8: The window pointer moves modulo NWINDOWS (default 8), depending on the trap type:
  - type 0x024 gives CWP-1;
  - types with bits 8:6 equal to 010 give CWP-CANSAVE-2;
  - types with bits 8:6 equal to 011 give CWP+1;
  - other types leave CWP unchanged.
- R9: `hdl_pc` is built from the trap base with bits 14:0 cleared. Bit 14 is set when `new_tl` exceeds 1, and the trap type occupies bits 13:5. `hdl_npc` is `hdl_pc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Trap request present |
| req_ready | output | 1 | Unit accepts a request |
| req_tt | input | 9 | Trap type |
| cur_pc | input | 64 | Current program counter |
| cur_npc | input | 64 | Current next program counter |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address-space identifier |
| cur_pstate | input | 12 | Processor state word |
| cur_cwp | input | CWPW (3) | Current window pointer |
| cur_cansave | input | CWPW (3) | Windows available to save |
| cur_gl | input | 3 | Global level |
| cur_tl | input | TLW (3) | Trap level |
| cur_tba | input | 64 | Trap base address |
| done | output | 1 | One-cycle completion pulse |
| err_state | output | 1 | Trap arrived at maximum level |
| new_tl | output | TLW (3) | Updated trap level |
| new_pstate | output | 12 | Updated processor state |
| new_cwp | output | CWPW (3) | Updated window pointer |
| new_gl | output | 3 | Updated global level |
| hdl_pc | output | 64 | Handler program counter |
| hdl_npc | output | 64 | Handler next program counter |
| rd_lvl | input | TLW (3) | Stack level to read |
| rd_tstate | output | 64 | Saved state word at `rd_lvl` |
| rd_tpc | output | 64 | Saved PC at `rd_lvl` |
| rd_tnpc | output | 64 | Saved NPC at `rd_lvl` |
| rd_tt | output | 9 | Saved trap type at `rd_lvl` |

## Verification
Some properties are checked on every cycle by the assertions:
- the completion pulse follows acceptance, and no completion occurs without one;
- on a normal entry the trap level advances by one, and the error flag appears only at the ceiling, with the echoed state;
- the handler NPC sits four above the handler PC;
- exactly one global-select bit is set, together with privilege and FPU enable;
- RED coincides with reaching the ceiling.

Other behaviour needs the bench's directed scenarios:
- the exact bit packing of the saved word;
- the trap-type-to-globals decode at range edges;
- window-pointer wrap for clean, spill and fill traps;
- global-level wrap;
- the absence of a stack write on an error trap, which is seen through the read port.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int TTW = 9;
  localparam int PSW = 12;

  // trap type codes the unit decodes
  localparam logic [8:0] TTC_CLEANWIN = 9'h024;
  localparam logic [8:0] TTC_IFAULT   = 9'h008;
  localparam logic [8:0] TTC_DFAULT   = 9'h030;
  localparam logic [8:0] TTC_INTVEC   = 9'h060;
  localparam logic [8:0] TTC_MMU_LO   = 9'h064;
  localparam logic [8:0] TTC_MMU_HI   = 9'h06F;
  localparam logic [2:0] GRP_SPILL    = 3'b010;
  localparam logic [2:0] GRP_FILL     = 3'b011;

  // processor state bit positions
  localparam int PSB_AG   = 0;
  localparam int PSB_PRIV = 2;
  localparam int PSB_PEF  = 4;
  localparam int PSB_RED  = 5;
  localparam int PSB_MG   = 10;
  localparam int PSB_IG   = 11;
  localparam logic [PSW-1:0] PS_KEEP_MASK = 12'hF3F;
  localparam logic [PSW-1:0] PS_GSEL_MASK = 12'hC01;

  typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
  typedef enum logic [1:0] {WOP_NONE, WOP_CLEAN, WOP_SPILL, WOP_FILL} wop_e;

  typedef struct packed {
    logic [63:0]    tstate;
    logic [63:0]    tpc;
    logic [63:0]    tnpc;
    logic [TTW-1:0] tt;
  } tstk_ent_t;

  localparam int ENT_W = $bits(tstk_ent_t);

endpackage

// File: rtl/tentry_classify.sv
module tentry_classify
  import trap_entry_pkg::*;
(
  input  logic [TTW-1:0] tt,
  output gsel_e          gsel,
  output wop_e           wop
);

  logic is_mmu;

  always_comb begin
    is_mmu = (tt == TTC_IFAULT) || (tt == TTC_DFAULT) ||
             ((tt >= TTC_MMU_LO) && (tt <= TTC_MMU_HI));
    if (tt == TTC_INTVEC)  gsel = GSEL_INT;
    else if (is_mmu)       gsel = GSEL_MMU;
    else                   gsel = GSEL_ALT;
  end

  always_comb begin
    if (tt == TTC_CLEANWIN)        wop = WOP_CLEAN;
    else if (tt[8:6] == GRP_SPILL) wop = WOP_SPILL;
    else if (tt[8:6] == GRP_FILL)  wop = WOP_FILL;
    else                           wop = WOP_NONE;
  end

endmodule

// File: rtl/tentry_level_ctl.sv
module tentry_level_ctl #(
  parameter int MAXTL = 6,
  parameter int TLW   = $clog2(MAXTL + 1)
) (
  input  logic [TLW-1:0] tl_in,
  output logic           fatal,
  output logic           red,
  output logic [TLW-1:0] tl_out
);

  always_comb begin
    fatal  = (int'(tl_in) >= MAXTL);
    red    = !fatal && (int'(tl_in) == MAXTL - 1);
    tl_out = fatal ? tl_in : tl_in + TLW'(1);
  end

endmodule

// File: rtl/tentry_vector_gen.sv
module tentry_vector_gen
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CWPW = $clog2(NWIN),
  parameter int TLW  = 3
) (
  input  gsel_e          gsel,
  input  wop_e           wop,
  input  logic           red,
  input  logic [TTW-1:0] tt,
  input  logic [CWPW-1:0] cwp,
  input  logic [CWPW-1:0] cansave,
  input  logic [63:15]   tba_hi,
  input  logic [TLW-1:0] tl_next,
  output logic [PSW-1:0] ps_new,
  output logic [CWPW-1:0] cwp_new,
  output logic [63:0]    hpc,
  output logic [63:0]    hnpc
);

  always_comb begin
    ps_new            = '0;
    ps_new[PSB_PEF]   = 1'b1;
    ps_new[PSB_PRIV]  = 1'b1;
    ps_new[PSB_RED]   = red;
    unique case (gsel)
      GSEL_INT: ps_new[PSB_IG] = 1'b1;
      GSEL_MMU: ps_new[PSB_MG] = 1'b1;
      default:  ps_new[PSB_AG] = 1'b1;
    endcase
  end

  always_comb begin
    int res;
    unique case (wop)
      WOP_CLEAN: res = int'(cwp) + NWIN - 1;
      WOP_SPILL: res = int'(cwp) + 2 * NWIN - int'(cansave) - 2;
      WOP_FILL:  res = int'(cwp) + 1;
      default:   res = int'(cwp);
    endcase
    cwp_new = CWPW'(res % NWIN);
  end

  always_comb begin
    hpc  = {tba_hi, (tl_next > TLW'(1)), tt, 5'b0};
    hnpc = hpc + 64'd4;
  end

endmodule

// File: rtl/tentry_state_stack.sv
module tentry_state_stack #(
  parameter int DEPTH = 7,
  parameter int AW    = $clog2(DEPTH),
  parameter int W     = 201
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (int'(raddr) < DEPTH) rdata <= mem[raddr];
    else                     rdata <= '0;
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int MAXTL = 6,
  parameter bit GL_EN = 1'b1,
  parameter int CWPW  = $clog2(NWIN),
  parameter int TLW   = $clog2(MAXTL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [8:0]      req_tt,
  input  logic [63:0]     cur_pc,
  input  logic [63:0]     cur_npc,
  input  logic [7:0]      cur_ccr,
  input  logic [7:0]      cur_asi,
  input  logic [11:0]     cur_pstate,
  input  logic [CWPW-1:0] cur_cwp,
  input  logic [CWPW-1:0] cur_cansave,
  input  logic [2:0]      cur_gl,
  input  logic [TLW-1:0]  cur_tl,
  input  logic [63:0]     cur_tba,
  output logic            done,
  output logic            err_state,
  output logic [TLW-1:0]  new_tl,
  output logic [11:0]     new_pstate,
  output logic [CWPW-1:0] new_cwp,
  output logic [2:0]      new_gl,
  output logic [63:0]     hdl_pc,
  output logic [63:0]     hdl_npc,
  input  logic [TLW-1:0]  rd_lvl,
  output logic [63:0]     rd_tstate,
  output logic [63:0]     rd_tpc,
  output logic [63:0]     rd_tnpc,
  output logic [8:0]      rd_tt
);

  localparam int DEPTH = MAXTL + 1;

  logic            accept;
  logic            fatal, red;
  logic [TLW-1:0]  tl_nx;
  gsel_e           gsel;
  wop_e            wop;
  logic [PSW-1:0]  ps_nx, ps_saved;
  logic [CWPW-1:0] cwp_nx;
  logic [63:0]     hpc_nx, hnpc_nx, tstate_w;
  logic [2:0]      gl_nx, gl_fld;
  tstk_ent_t       wr_ent, rd_ent;
  logic            tba_unused;

  assign tba_unused = ^cur_tba[14:0];
  assign accept     = req_valid && req_ready;

  tentry_level_ctl #(.MAXTL(MAXTL), .TLW(TLW)) u_lvl (
    .tl_in(cur_tl), .fatal(fatal), .red(red), .tl_out(tl_nx)
  );

  tentry_classify u_cls (.tt(req_tt), .gsel(gsel), .wop(wop));

  tentry_vector_gen #(.NWIN(NWIN), .CWPW(CWPW), .TLW(TLW)) u_vec (
    .gsel(gsel), .wop(wop), .red(red), .tt(req_tt), .cwp(cur_cwp),
    .cansave(cur_cansave), .tba_hi(cur_tba[63:15]), .tl_next(tl_nx),
    .ps_new(ps_nx), .cwp_new(cwp_nx), .hpc(hpc_nx), .hnpc(hnpc_nx)
  );

  generate
    if (GL_EN) begin : g_gl_on
      assign gl_nx  = cur_gl + 3'd1;
      assign gl_fld = cur_gl;
    end else begin : g_gl_off
      assign gl_nx  = cur_gl;
      assign gl_fld = 3'd0;
    end
  endgenerate

  always_comb begin
    ps_saved              = cur_pstate;
    ps_saved[PSB_RED]     = cur_pstate[PSB_RED] | red;
    tstate_w              = '0;
    tstate_w[42:40]       = gl_fld;
    tstate_w[39:32]       = cur_ccr;
    tstate_w[31:24]       = cur_asi;
    tstate_w[19:8]        = ps_saved & PS_KEEP_MASK;
    tstate_w[CWPW-1:0]    = cur_cwp;
    wr_ent.tstate         = tstate_w;
    wr_ent.tpc            = cur_pc;
    wr_ent.tnpc           = cur_npc;
    wr_ent.tt             = req_tt;
  end

  tentry_state_stack #(.DEPTH(DEPTH), .AW(TLW), .W(ENT_W)) u_stk (
    .clk(clk), .we(accept && !fatal), .waddr(tl_nx), .wdata(wr_ent),
    .raddr(rd_lvl), .rdata(rd_ent)
  );

  assign rd_tstate = rd_ent.tstate;
  assign rd_tpc    = rd_ent.tpc;
  assign rd_tnpc   = rd_ent.tnpc;
  assign rd_tt     = rd_ent.tt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready  <= 1'b0;
      done       <= 1'b0;
      err_state  <= 1'b0;
      new_tl     <= '0;
      new_pstate <= '0;
      new_cwp    <= '0;
      new_gl     <= '0;
      hdl_pc     <= '0;
      hdl_npc    <= '0;
    end else begin
      req_ready <= 1'b1;
      done      <= accept;
      err_state <= accept && fatal;
      if (accept) begin
        if (fatal) begin
          new_tl     <= cur_tl;
          new_pstate <= cur_pstate;
          new_cwp    <= cur_cwp;
          new_gl     <= cur_gl;
          hdl_pc     <= cur_pc;
          hdl_npc    <= cur_npc;
        end else begin
          new_tl     <= tl_nx;
          new_pstate <= ps_nx;
          new_cwp    <= cwp_nx;
          new_gl     <= gl_nx;
          hdl_pc     <= hpc_nx;
          hdl_npc    <= hnpc_nx;
        end
      end
    end
  end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_entry_pkg::*;
#(
  parameter int MAXTL = 6,
  parameter int TLW   = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [TLW-1:0] cur_tl,
  input logic [63:0]    cur_pc,
  input logic [11:0]    cur_pstate,
  input logic           done,
  input logic           err_state,
  input logic [TLW-1:0] new_tl,
  input logic [11:0]    new_pstate,
  input logic [63:0]    hdl_pc,
  input logic [63:0]    hdl_npc
);

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> done);  // R1

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_valid && req_ready));  // R1

  AST_ERR_ONLY_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    (done && err_state) |-> (int'($past(cur_tl)) >= MAXTL));  // R2

  AST_ERR_ECHO: assert property (@(posedge clk) disable iff (rst)
    (done && err_state) |-> (hdl_pc == $past(cur_pc) && new_pstate == $past(cur_pstate)));  // R2

  AST_TL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (done && !err_state) |-> (new_tl == TLW'($past(cur_tl) + 1'b1)));  // R3

  AST_RED_AT_CEILING: assert property (@(posedge clk) disable iff (rst)
    (done && !err_state) |-> (new_pstate[PSB_RED] == (int'(new_tl) == MAXTL)));  // R3

  AST_ONE_GLOBAL_SET: assert property (@(posedge clk) disable iff (rst)
    (done && !err_state) |-> ($countones(new_pstate & PS_GSEL_MASK) == 1 &&
                              new_pstate[PSB_PRIV] && new_pstate[PSB_PEF]));  // R7

  AST_NPC_STEP: assert property (@(posedge clk) disable iff (rst)
    (done && !err_state) |-> (hdl_npc == hdl_pc + 64'd4));  // R9

endmodule

bind trap_entry_unit trap_entry_chk #(.MAXTL(MAXTL), .TLW(TLW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cur_tl(cur_tl), .cur_pc(cur_pc), .cur_pstate(cur_pstate), .done(done),
  .err_state(err_state), .new_tl(new_tl), .new_pstate(new_pstate),
  .hdl_pc(hdl_pc), .hdl_npc(hdl_npc)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [8:0]  req_tt = '0;
  logic [63:0] cur_pc = '0, cur_npc = '0, cur_tba = '0;
  logic [7:0]  cur_ccr = '0, cur_asi = '0;
  logic [11:0] cur_pstate = '0;
  logic [2:0]  cur_cwp = '0, cur_cansave = '0, cur_gl = '0, cur_tl = '0;
  logic        done, err_state;
  logic [2:0]  new_tl, new_cwp, new_gl;
  logic [11:0] new_pstate;
  logic [63:0] hdl_pc, hdl_npc;
  logic [2:0]  rd_lvl = '0;
  logic [63:0] rd_tstate, rd_tpc, rd_tnpc;
  logic [8:0]  rd_tt;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          err;
    logic [2:0]  tl;
    logic [11:0] ps;
    logic [2:0]  cwp;
    logic [2:0]  gl;
    logic [63:0] pc;
    logic [63:0] npc;
  } exp_t;

  exp_t sb_q[$];
  logic [63:0] sv_ts [8];
  logic [63:0] sv_pc [8];
  logic [63:0] sv_npc[8];
  logic [8:0]  sv_tt [8];

  trap_entry_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tt(req_tt), .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr),
    .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_cwp(cur_cwp),
    .cur_cansave(cur_cansave), .cur_gl(cur_gl), .cur_tl(cur_tl),
    .cur_tba(cur_tba), .done(done), .err_state(err_state), .new_tl(new_tl),
    .new_pstate(new_pstate), .new_cwp(new_cwp), .new_gl(new_gl),
    .hdl_pc(hdl_pc), .hdl_npc(hdl_npc), .rd_lvl(rd_lvl),
    .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: computes the expected result from the requirements and queues it
  task automatic send(input logic [8:0] tt, input logic [2:0] tl, input logic [11:0] ps,
                      input logic [2:0] cwp, input logic [2:0] cs, input logic [2:0] gl,
                      input logic [7:0] ccr, input logic [7:0] asi,
                      input logic [63:0] pc, input logic [63:0] tba);
    exp_t e;
    bit red;
    logic [11:0] sps, g;
    @(negedge clk);
    req_tt = tt; cur_tl = tl; cur_pstate = ps; cur_cwp = cwp; cur_cansave = cs;
    cur_gl = gl; cur_ccr = ccr; cur_asi = asi; cur_pc = pc; cur_npc = pc + 64'd4;
    cur_tba = tba;
    if (tl >= 3'd6) begin
      e.err = 1'b1; e.tl = tl; e.ps = ps; e.cwp = cwp; e.gl = gl;
      e.pc = pc; e.npc = pc + 64'd4;
    end else begin
      e.err = 1'b0;
      red = (tl == 3'd5);
      e.tl = tl + 3'd1;
      sps = ps | (red ? 12'h020 : 12'h000);
      if (tt == 9'h060) g = 12'h800;
      else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) g = 12'h400;
      else g = 12'h001;
      e.ps = 12'h014 | g | (red ? 12'h020 : 12'h000);
      if (tt == 9'h024)           e.cwp = cwp - 3'd1;
      else if (tt[8:6] == 3'b010) e.cwp = cwp - cs - 3'd2;
      else if (tt[8:6] == 3'b011) e.cwp = cwp + 3'd1;
      else                        e.cwp = cwp;
      e.gl = gl + 3'd1;
      e.pc = {tba[63:15], 15'b0} | ((e.tl > 3'd1) ? 64'h4000 : 64'h0) | ({55'b0, tt} << 5);
      e.npc = e.pc + 64'd4;
      sv_ts[e.tl]  = ({56'b0, ccr} << 32) | ({61'b0, gl} << 40) | ({56'b0, asi} << 24) |
                     ({52'b0, sps & 12'hF3F} << 8) | {61'b0, cwp};
      sv_pc[e.tl]  = pc;
      sv_npc[e.tl] = pc + 64'd4;
      sv_tt[e.tl]  = tt;
    end
    sb_q.push_back(e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a completion appears
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) chk("R1 unexpected done", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.err ? "R2 err_state" : "R2 err_state clear", {63'b0, err_state}, {63'b0, e.err});
        chk(e.err ? "R2 tl held"  : "R3 tl",     {61'b0, new_tl},     {61'b0, e.tl});
        chk(e.err ? "R2 ps held"  : "R7 pstate", {52'b0, new_pstate}, {52'b0, e.ps});
        chk(e.err ? "R2 cwp held" : "R8 cwp",    {61'b0, new_cwp},    {61'b0, e.cwp});
        chk(e.err ? "R2 gl held"  : "R6 gl",     {61'b0, new_gl},     {61'b0, e.gl});
        chk(e.err ? "R2 pc held"  : "R9 pc",     hdl_pc,  e.pc);
        chk(e.err ? "R2 npc held" : "R9 npc",    hdl_npc, e.npc);
      end
    end
  end

  task automatic rd(input logic [2:0] lvl, input string tag);
    @(negedge clk);
    rd_lvl = lvl;
    @(negedge clk);
    chk({tag, " R4/R6 tstate"}, rd_tstate, sv_ts[lvl]);
    chk({tag, " R5 tpc"},  rd_tpc,  sv_pc[lvl]);
    chk({tag, " R5 tnpc"}, rd_tnpc, sv_npc[lvl]);
    chk({tag, " R5 tt"},   {55'b0, rd_tt}, {55'b0, sv_tt[lvl]});
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [63:0] TBA0 = 64'hFFFF_0000_0001_7FFF;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {63'b0, req_ready}, 64'd0);
    chk("R1 done in reset",  {63'b0, done}, 64'd0);
    chk("R1 err in reset",   {63'b0, err_state}, 64'd0);
    chk("R1 pc in reset",    hdl_pc, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {63'b0, req_ready}, 64'd1);

    // interrupt vector, level 0 -> 1
    send(9'h060, 3'd0, 12'h002, 3'd3, 3'd2, 3'd0, 8'hA5, 8'h80, 64'h1000, TBA0);
    @(negedge clk);
    chk("R1 done single pulse", {63'b0, done}, 64'd0);
    // MMU range member, every pstate bit set to exercise the save mask
    send(9'h06A, 3'd1, 12'hFFF, 3'd5, 3'd1, 3'd1, 8'h3C, 8'h14, 64'h2000, TBA0);
    // instruction fault code, range edges 0x064 and 0x06F
    send(9'h008, 3'd2, 12'h000, 3'd2, 3'd0, 3'd2, 8'h01, 8'h02, 64'h3000, TBA0);
    send(9'h064, 3'd0, 12'h000, 3'd2, 3'd0, 3'd2, 8'h01, 8'h02, 64'h3100, TBA0);
    send(9'h06F, 3'd0, 12'h000, 3'd2, 3'd0, 3'd2, 8'h01, 8'h02, 64'h3200, TBA0);
    send(9'h070, 3'd0, 12'h000, 3'd2, 3'd0, 3'd2, 8'h01, 8'h02, 64'h3300, TBA0);
    // window traps: clean wraps 0 -> 7, spill 1-3-2 -> 4, fill 7 -> 0
    send(9'h024, 3'd0, 12'h000, 3'd0, 3'd4, 3'd0, 8'h00, 8'h00, 64'h4000, TBA0);
    send(9'h085, 3'd0, 12'h000, 3'd1, 3'd3, 3'd0, 8'h00, 8'h00, 64'h4100, TBA0);
    send(9'h0C7, 3'd0, 12'h000, 3'd7, 3'd3, 3'd0, 8'h00, 8'h00, 64'h4200, TBA0);
    // trap instructions take the alternate-globals path
    send(9'h103, 3'd3, 12'h002, 3'd6, 3'd1, 3'd3, 8'h77, 8'h88, 64'h5000, TBA0);
    send(9'h1A0, 3'd4, 12'h000, 3'd6, 3'd1, 3'd4, 8'h11, 8'h22, 64'h6000, TBA0);
    // one below the ceiling: RED
    send(9'h030, 3'd5, 12'h002, 3'd4, 3'd2, 3'd5, 8'hC3, 8'h5A, 64'h7000, TBA0);
    // at and above the ceiling: error, no write
    send(9'h040, 3'd6, 12'h123, 3'd1, 3'd1, 3'd6, 8'hEE, 8'hEE, 64'hDEAD_0000, TBA0);
    send(9'h041, 3'd7, 12'h456, 3'd2, 3'd1, 3'd7, 8'hEE, 8'hEE, 64'hBEEF_0000, TBA0);
    // global level wrap 7 -> 0
    send(9'h050, 3'd0, 12'h000, 3'd2, 3'd1, 3'd7, 8'h9F, 8'hF9, 64'h8000, TBA0);

    repeat (2) @(negedge clk);
    chk("R1 scoreboard drained", 64'(sb_q.size()), 64'd0);

    rd(3'd1, "lvl1");
    rd(3'd2, "lvl2");
    rd(3'd3, "lvl3");
    rd(3'd4, "lvl4");
    rd(3'd5, "lvl5");
    rd(3'd6, "R2 lvl6 kept");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule